// File: doc/BRIEF.md
# Four-Stage Shift Register with J / K-bar First Stage

This block is a small register that, on every rising clock edge, does one of two things. It either captures a full word from its parallel inputs, or it moves every stage one place toward the last stage. During a shift, the bit that enters stage 0 comes from a J/K pair that behaves like a JK flip-flop. J is active high and the K pin is active low, so each combination of the two gives set, clear, hold or toggle of stage 0.

An active-low reset clears every stage at once, without waiting for a clock edge. The outputs are each stage and the inverse of the last stage. The block suits serial-in/parallel-out conversion, parallel-in/serial-out conversion, and simple counters built from feedback around it.

Top module: `jk_shift_reg`

## Requirements
- R1: Driving `rst_n` low clears all stages to 0 right away, before any clock edge arrives.
- R2: While `rst_n` is low, rising clock edges leave every stage at 0, whatever `load_n`, `par_in`, `j_in` and `kbar_in` are.
- R3: With `load_n` low at a rising edge, `q_out[i]` takes `par_in[i]` for every bit i. `j_in` and `kbar_in` have no effect on that edge.
- R4: With `load_n` high at a rising edge, `q_out[i]` takes the old `q_out[i-1]` for i = 1..3. `par_in` has no effect on that edge.
- R5: In a shift with `j_in`=0 and `kbar_in`=0, stage 0 becomes 0.
- R6: In a shift with `j_in`=1 and `kbar_in`=1, stage 0 becomes 1.
- R7: In a shift with `j_in`=0 and `kbar_in`=1, stage 0 keeps its old value.
- R8: In a shift with `j_in`=1 and `kbar_in`=0, stage 0 becomes the inverse of its old value.
- R9: `q_last_n` always equals the inverse of `q_out[3]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all transfers happen on its rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Low selects parallel capture, high selects shift |
| j_in | input | 1 | Active-high J input of stage 0 |
| kbar_in | input | 1 | Active-low K input of stage 0 |
| par_in | input | 4 | Parallel data word; bit i goes to stage i |
| q_out | output | 4 | Stage values; bit 0 is the first stage |
| q_last_n | output | 1 | Inverse of the last stage |

## Verification
The hardest case to reach from the ports is a reset that arrives between clock edges while the register holds a nonzero value. The bench first loads a nonzero word. It then pulls `rst_n` low a few nanoseconds after a rising edge and checks the outputs before the next edge. Next it clocks with `load_n` low and all-ones data to show that reset wins. Reset is released just after a falling edge, and a reference model is then compared after every edge. The sweep covers each of the 16 starting words crossed with each J/K-bar combination, and each combination is held for four shifts.

// File: rtl/jk_shift_reg.sv
module jk_shift_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             j_in,
  input  logic             kbar_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q_out,
  output logic             q_last_n
);

  logic first_next;

  always_comb begin
    case ({j_in, kbar_in})
      2'b00:   first_next = 1'b0;
      2'b01:   first_next = q_out[0];
      2'b10:   first_next = ~q_out[0];
      default: first_next = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_out <= '0;
    else if (!load_n) q_out <= par_in;
    else              q_out <= {q_out[WIDTH-2:0], first_next};
  end

  assign q_last_n = ~q_out[WIDTH-1];

  assert_reset_wins_R2: assert property (@(posedge clk)
    !rst_n |-> q_out == '0);

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(load_n) |-> q_out == $past(par_in));

  assert_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(load_n) |-> q_out[WIDTH-1:1] == $past(q_out[WIDTH-2:0]));

  assert_jk_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(load_n) && !$past(j_in) && !$past(kbar_in) |-> !q_out[0]);

  assert_jk_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(load_n) && $past(j_in) && $past(kbar_in) |-> q_out[0]);

  assert_jk_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(load_n) && !$past(j_in) && $past(kbar_in) |-> q_out[0] == $past(q_out[0]));

  assert_jk_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(load_n) && $past(j_in) && !$past(kbar_in) |-> q_out[0] != $past(q_out[0]));

endmodule

// File: tb/jk_shift_reg_bench.sv
module jk_shift_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_n = 1'b1;
  logic       j_in = 1'b0;
  logic       kbar_in = 1'b0;
  logic [3:0] par_in = 4'h0;
  logic [3:0] q_out;
  logic       q_last_n;

  int checks = 0;
  int fails = 0;
  logic [3:0] model = 4'h0;

  always #5 clk = ~clk;

  jk_shift_reg #(.WIDTH(4)) u_jk_shift_reg (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .j_in(j_in),
    .kbar_in(kbar_in), .par_in(par_in), .q_out(q_out), .q_last_n(q_last_n)
  );

  task automatic check(input string req, input logic [3:0] exp);
    checks++;
    if (q_out !== exp) begin
      fails++;
      $display("FAIL %s q_out actual=%h expected=%h", req, q_out, exp);
    end
    checks++;
    if (q_last_n !== ~exp[3]) begin
      fails++;
      $display("FAIL R9 q_last_n actual=%b expected=%b", q_last_n, ~exp[3]);
    end
  endtask

  task automatic clock_step;
    @(posedge clk);
    #2;
  endtask

  function automatic logic first_bit(input logic j, input logic kb, input logic q0);
    case ({j, kb})
      2'b00:   return 1'b0;
      2'b01:   return q0;
      2'b10:   return ~q0;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    #2;
    check("R1 reset at time zero", 4'h0);
    @(negedge clk);
    load_n = 1'b0; par_in = 4'hF;
    clock_step();
    check("R2 load ignored in reset", 4'h0);
    @(negedge clk); #1;
    rst_n = 1'b1;
    load_n = 1'b1;
    model = 4'h0;

    for (int v = 0; v < 16; v++) begin
      for (int jk = 0; jk < 4; jk++) begin
        @(negedge clk);
        load_n = 1'b0; par_in = 4'(v);
        j_in = jk[1]; kbar_in = ~jk[0];
        clock_step();
        model = 4'(v);
        check("R3 parallel load, J/K ignored", model);
        for (int s = 0; s < 4; s++) begin
          @(negedge clk);
          load_n = 1'b1;
          j_in = jk[1]; kbar_in = jk[0];
          par_in = ~model;
          clock_step();
          model = {model[2:0], first_bit(j_in, kbar_in, model[0])};
          case ({j_in, kbar_in})
            2'b00:   check("R4 R5 shift with clear", model);
            2'b11:   check("R4 R6 shift with set", model);
            2'b01:   check("R4 R7 shift with hold", model);
            default: check("R4 R8 shift with toggle", model);
          endcase
        end
      end
    end

    @(negedge clk);
    load_n = 1'b0; par_in = 4'hA;
    clock_step();
    check("R3 load before reset", 4'hA);
    #1;
    rst_n = 1'b0;
    #1;
    check("R1 mid-cycle reset clears at once", 4'h0);
    @(negedge clk);
    load_n = 1'b0; par_in = 4'hF; j_in = 1'b1; kbar_in = 1'b1;
    clock_step();
    check("R2 reset beats load", 4'h0);
    @(negedge clk);
    load_n = 1'b1;
    clock_step();
    check("R2 reset beats shift", 4'h0);
    @(negedge clk); #1;
    rst_n = 1'b1;
    clock_step();
    check("R6 shift after reset release", 4'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule